// File: doc/BRIEF.md
# Legacy Processor Presence Bitmap Port

This block holds one presence bit for every processor the platform can carry, and firmware reads it one byte at a time. The bit for a processor sits at the position equal to its interrupt-controller ID. The boot processor's bit reads as 1 at all times. When the platform hot-adds a processor, it pulses an add strobe with the processor's ID. The block then sets that bit and flags general-purpose event 2. The firmware event handler sees that flag through an interrupt line.

Software cannot change the bitmap. Writes to it are dropped, with one exception. A zero byte written anywhere in the first 32-bit word means that software wants to leave legacy mode. The block then raises a sticky switch output, which another register interface can use to take over. From that point on the bitmap reads as zero and hot-add strobes are ignored. Processors can be added but never removed, so a set bit stays set until reset.

A second address space, picked by a space-select input, holds the event status byte and the event enable byte.

Top module: `cpuhp_legacy_map`

## Requirements
- R1: After reset the bitmap holds only bit 0. Event status, event enable, the switch output, the interrupt output and the read data are all zero.
- R2: A read of bitmap byte n (space 0) returns presence bits 8n to 8n+7, with the LSB holding bit 8n. The data appears on rdata_o in the cycle after rd_i and holds until the next read.
- R3: Bit 0 of bitmap byte 0 reads as 1 for as long as legacy mode is active.
- R4: A hot-add with ID below NUM_CPU sets bit ID. A hot-add with ID at or above NUM_CPU changes no bit and does not set event status.
- R5: Bitmap bytes that hold no populated processor bit read as zero.
- R6: Writes to the bitmap space never change any presence bit.
- R7: Writing the byte 0x00 to bitmap address 0, 1, 2 or 3 raises legacy_off_o in the next cycle. It stays high until reset. Any other bitmap write leaves it unchanged.
- R8: While legacy_off_o is high, every bitmap read returns zero and hot-add strobes are ignored.
- R9: An accepted hot-add sets the event status bit, which is bit 2 of event-space address 0. Writing that address with bit 2 set clears the status. A write with bit 2 clear leaves it unchanged. If a clear and a hot-add fall in the same cycle, the hot-add wins.
- R10: The event enable bit is bit 2 of event-space address 1 and can be written and read back. sci_o equals status AND enable.
- R11: Only reset clears a presence bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| space_i | input | 1 | 0 = bitmap window, 1 = event registers |
| addr_i | input | ADDR_W | Byte address within the selected space |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| add_valid_i | input | 1 | Hot-add strobe |
| add_id_i | input | ID_W | Interrupt-controller ID of the added processor |
| sci_o | output | 1 | Event interrupt to firmware |
| legacy_off_o | output | 1 | Sticky legacy-mode exit |

## Verification
A lost or spurious presence bit shows up in the very next bitmap read of the byte that holds it, one cycle after the read strobe. A status flag in the wrong state shows up at once on sci_o whenever enable is set, and in the next read of the event status byte. A switch flag that sets at the wrong time, or fails to stay set, shows on legacy_off_o one cycle after the write that caused it. It also shows as bitmap reads that come back nonzero or wrongly zero.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
  typedef enum logic {SP_MAP = 1'b0, SP_EVT = 1'b1} space_e;
  localparam int GPE_BIT  = 2;
  localparam int EVT_STS  = 0;
  localparam int EVT_EN   = 1;
  localparam int SW_BYTES = 4;
endpackage

// File: rtl/cpuhp_presence_map.sv
module cpuhp_presence_map #(
  parameter int NUM_CPU = 16,
  parameter int ID_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               add_i,
  input  logic [ID_W-1:0]    add_id_i,
  output logic [NUM_CPU-1:0] map_o,
  output logic               add_ok_o
);
  localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_CPU);

  assign add_ok_o = add_i && ({1'b0, add_id_i} < LIMIT);

  // boot processor hard-wired present
  assign map_o[0] = 1'b1;

  for (genvar i = 1; i < NUM_CPU; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else if (add_i && add_id_i == ID_W'(i)) bit_q <= 1'b1;
    end
    assign map_o[i] = bit_q;
  end
endmodule

// File: rtl/cpuhp_mode_switch.sv
module cpuhp_mode_switch #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              off_o
);
  import cpuhp_pkg::*;
  localparam int LSB = $clog2(SW_BYTES);

  logic hit;
  assign hit = map_wr_i && (addr_i[ADDR_W-1:LSB] == '0) && (wdata_i == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_o <= 1'b0;
    else if (hit) off_o <= 1'b1;
  end
endmodule

// File: rtl/cpuhp_gpe_flag.sv
module cpuhp_gpe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_d_i,
  output logic sts_o,
  output logic en_o,
  output logic sci_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_o <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      if (set_i)      sts_o <= 1'b1;   // set beats clear
      else if (clr_i) sts_o <= 1'b0;
      if (en_wr_i)    en_o  <= en_d_i;
    end
  end

  assign sci_o = sts_o & en_o;
endmodule

// File: rtl/cpuhp_read_mux.sv
module cpuhp_read_mux #(
  parameter int NUM_CPU   = 16,
  parameter int WIN_BYTES = 32,
  parameter int ADDR_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               space_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_CPU-1:0] map_i,
  input  logic               off_i,
  input  logic               sts_i,
  input  logic               en_i,
  output logic [7:0]         rdata_o
);
  import cpuhp_pkg::*;
  localparam int WIN_BITS = WIN_BYTES * 8;

  logic [WIN_BITS-1:0] win;
  for (genvar b = 0; b < WIN_BITS; b++) begin : g_win
    if (b < NUM_CPU) begin : g_pop
      assign win[b] = map_i[b];
    end else begin : g_pad
      assign win[b] = 1'b0;
    end
  end

  logic [7:0] map_byte, evt_byte, nxt;

  always_comb begin
    map_byte = off_i ? 8'h00 : win[{addr_i, 3'b000} +: 8];
    evt_byte = '0;
    if (addr_i == ADDR_W'(EVT_STS))     evt_byte[GPE_BIT] = sts_i;
    else if (addr_i == ADDR_W'(EVT_EN)) evt_byte[GPE_BIT] = en_i;
    nxt = (space_i == SP_EVT) ? evt_byte : map_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= nxt;
  end
endmodule

// File: rtl/cpuhp_legacy_map.sv
module cpuhp_legacy_map #(
  parameter int NUM_CPU   = 16,
  parameter int WIN_BYTES = 32,
  parameter int ID_W      = 8,
  parameter int ADDR_W    = $clog2(WIN_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              add_valid_i,
  input  logic [ID_W-1:0]   add_id_i,
  output logic              sci_o,
  output logic              legacy_off_o
);
  import cpuhp_pkg::*;

  logic [NUM_CPU-1:0] map_q;
  logic add_ok, sts, en, map_wr, evt_wr;

  assign map_wr = wr_i && (space_i == SP_MAP);
  assign evt_wr = wr_i && (space_i == SP_EVT);

  cpuhp_presence_map #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_map (
    .clk_i, .rst_ni,
    .add_i    (add_valid_i && !legacy_off_o),
    .add_id_i (add_id_i),
    .map_o    (map_q),
    .add_ok_o (add_ok)
  );

  cpuhp_mode_switch #(.ADDR_W(ADDR_W)) u_sw (
    .clk_i, .rst_ni,
    .map_wr_i (map_wr),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .off_o    (legacy_off_o)
  );

  cpuhp_gpe_flag u_gpe (
    .clk_i, .rst_ni,
    .set_i   (add_ok),
    .clr_i   (evt_wr && addr_i == ADDR_W'(EVT_STS) && wdata_i[GPE_BIT]),
    .en_wr_i (evt_wr && addr_i == ADDR_W'(EVT_EN)),
    .en_d_i  (wdata_i[GPE_BIT]),
    .sts_o   (sts),
    .en_o    (en),
    .sci_o   (sci_o)
  );

  cpuhp_read_mux #(.NUM_CPU(NUM_CPU), .WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni,
    .rd_i    (rd_i),
    .space_i (space_i),
    .addr_i  (addr_i),
    .map_i   (map_q),
    .off_i   (legacy_off_o),
    .sts_i   (sts),
    .en_i    (en),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/cpuhp_legacy_map_chk.sv
module cpuhp_legacy_map_chk #(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               space_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic               add_valid_i,
  input logic               sci_o,
  input logic               legacy_off_o,
  input logic [NUM_CPU-1:0] map_i
);
  AST_SWITCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_off_o |=> legacy_off_o); // R7
  AST_SWITCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(legacy_off_o) |-> $past(wr_i && !space_i && addr_i[ADDR_W-1:2] == '0 && wdata_i == 8'h00)); // R7
  AST_DEAD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !space_i && legacy_off_o) |=> rdata_o == 8'h00); // R8
  AST_BOOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !space_i && addr_i == '0 && !legacy_off_o) |=> rdata_o[0]); // R3
  AST_NO_REMOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_i != '0) |=> ((map_i & $past(map_i)) == $past(map_i))); // R11
  AST_SCI_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sci_o) |-> $past(add_valid_i || (wr_i && space_i))); // R10
endmodule

bind cpuhp_legacy_map cpuhp_legacy_map_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .space_i(space_i), .addr_i(addr_i), .rd_i(rd_i),
  .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .add_valid_i(add_valid_i),
  .sci_o(sci_o), .legacy_off_o(legacy_off_o), .map_i(map_q)
);

// File: tb/sim_cpuhp_legacy_map.sv
module sim_cpuhp_legacy_map;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU    = 16;
  localparam int WIN_BYTES  = 32;
  localparam int ID_W       = 8;
  localparam int AW         = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic space = 1'b0, rd = 1'b0, wr = 1'b0, add_v = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [ID_W-1:0] add_id = '0;
  logic sci, off;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [WIN_BYTES*8-1:0] m_map;
  logic m_sts, m_en, m_mode;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuhp_legacy_map #(.NUM_CPU(NUM_CPU), .WIN_BYTES(WIN_BYTES), .ID_W(ID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .space_i(space), .addr_i(addr), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .add_valid_i(add_v),
    .add_id_i(add_id), .sci_o(sci), .legacy_off_o(off)
  );

  function automatic logic [7:0] exp_byte(logic sel, logic [AW-1:0] a);
    logic [7:0] v = '0;
    if (!sel) v = m_mode ? 8'h00 : m_map[{a, 3'b000} +: 8];
    else if (a == 0) v[2] = m_sts;
    else if (a == 1) v[2] = m_en;
    return v;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_map = '0; m_map[0] = 1'b1; m_sts = 0; m_en = 0; m_mode = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; model_reset();
    repeat (2) @(negedge clk); rst_ni = 1;
  endtask

  // driver: pushes expectation for the monitor
  task automatic rd_b(logic sel, logic [AW-1:0] a, string tag);
    @(negedge clk); space = sel; addr = a; rd = 1;
    exp_q.push_back(exp_byte(sel, a)); tag_q.push_back(tag);
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_b(logic sel, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); space = sel; addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    if (!sel) begin
      if (a < 4 && d == 8'h00) m_mode = 1;
    end else if (a == 0) begin
      if (d[2]) m_sts = 0;
    end else if (a == 1) m_en = d[2];
  endtask

  task automatic hot_add(int id, bit clr);
    @(negedge clk); add_v = 1; add_id = ID_W'(id);
    if (clr) begin space = 1; addr = 0; wdata = 8'h04; wr = 1; end
    @(negedge clk); add_v = 0; wr = 0;
    if (clr) m_sts = 0;
    if (!m_mode && id < NUM_CPU) begin m_map[id] = 1; m_sts = 1; end
  endtask

  task automatic check_pins(string tag);
    check8({tag, " sci"}, {7'b0, sci}, {7'b0, m_sts & m_en});
    check8({tag, " off"}, {7'b0, off}, {7'b0, m_mode});
  endtask

  // monitor
  initial begin
    forever begin
      logic fire;
      @(posedge clk); fire = rd;
      @(negedge clk);
      if (fire && exp_q.size() > 0) check8(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state
    check8("R1 rdata", rdata, 8'h00);
    check_pins("R1");
    rd_b(0, 0, "R1/R3 byte0");
    rd_b(0, 1, "R1 byte1");
    rd_b(1, 0, "R1 status");
    rd_b(1, 1, "R1 enable");
    // R10 enable
    wr_b(1, 1, 8'h04);
    rd_b(1, 1, "R10 enable readback");
    check_pins("R10 enabled no event");
    // R4 / R9 hot-add
    hot_add(5, 0);
    check_pins("R9/R10 add");
    rd_b(0, 0, "R2/R4 byte0");
    rd_b(1, 0, "R9 status");
    hot_add(12, 0);
    hot_add(0, 0);
    rd_b(0, 1, "R2/R4 byte1");
    rd_b(0, 0, "R3 byte0");
    wr_b(1, 0, 8'h04);
    check_pins("R9 cleared");
    hot_add(20, 0);
    check_pins("R4 out of range no status");
    for (int a = 0; a < WIN_BYTES; a++) rd_b(0, AW'(a), "R5/R4 window");
    // R6 writes ignored, no switch
    wr_b(0, 0, 8'hAA);
    wr_b(0, 1, 8'h55);
    wr_b(0, 4, 8'h00);
    wr_b(0, 3, 8'hFF);
    check_pins("R7 no switch");
    rd_b(0, 0, "R6 byte0");
    rd_b(0, 1, "R6 byte1");
    rd_b(0, 4, "R6 byte4");
    // R9 clear with bit2 low, and set-wins
    hot_add(3, 0);
    wr_b(1, 0, 8'hFB);
    rd_b(1, 0, "R9 no clear");
    hot_add(7, 1);
    check_pins("R9 set wins");
    rd_b(1, 0, "R9 set wins status");
    wr_b(1, 1, 8'h00);
    check_pins("R10 disabled");
    rd_b(1, 0, "R10 status kept");
    for (int a = 0; a < 3; a++) rd_b(0, AW'(a), "R11 bits kept");
    // R7 switch
    wr_b(1, 0, 8'h04);
    wr_b(0, 2, 8'h00);
    check_pins("R7 switch");
    rd_b(0, 0, "R8 dead byte0");
    rd_b(0, 1, "R8 dead byte1");
    hot_add(9, 0);
    rd_b(1, 0, "R8 add ignored");
    wr_b(0, 0, 8'h33);
    check_pins("R7 sticky");
    // reset clears all
    do_reset();
    check_pins("R1 after reset");
    rd_b(0, 0, "R11/R1 byte0");
    rd_b(0, 1, "R11/R1 byte1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule